// File: doc/BRIEF.md
# Closed Caption Line Data Decoder

This block pulls the two caption characters out of one video line. A slicer ahead of it turns the line into a serial stream that has already been sampled at the bit rate. That stream arrives as a data bit with a one-cycle strobe for each bit. A line-start pulse marks the beginning of each line. After each line start the decoder looks for the alternating clock run-in and the start pattern. It then collects sixteen payload bits and splits them into two characters, each sent least significant bit first as seven data bits and a parity bit.

When both characters are complete, they go into two byte registers. A parity error flag is set for each character whose one-count is even. An available flag is also raised. A host reads the byte registers and a status register through a small read port. Reading the second byte register consumes the capture and clears the available flag. If a new line starts before the payload is complete, the partial capture is discarded and the registers keep their previous contents.

Top module: `ccd_line_decoder`

## Requirements
- R1: After reset the status register (address 2) reads zero: the available flag and both parity error flags are low.
- R2: Payload bits are accepted only after the ten-bit preamble 1,0,1,0,1,0,1,0,0,1 (run-in then start pattern, in arrival order) has been seen while hunting. A line whose run-in is broken produces no capture.
- R3: Payload bits arrive least significant first. Strobed payload bit k goes to bit k of byte register 0 (address 0) for k = 0..7. Bit k+8 goes to bit k of byte register 1 (address 1). Bit 7 of each register is that character's parity bit.
- R4: The available flag (status bit 0) is set on the clock edge that takes the sixteenth payload bit, and both byte registers are updated on that same edge.
- R5: Parity is odd. Status bit 1 (character 0) and status bit 2 (character 1) are set when the captured 8-bit value has an even number of ones, and cleared otherwise. Status bits 7..3 read zero.
- R6: The read port is combinational. Address 0 returns byte register 0, address 1 returns byte register 1, address 2 returns status, and address 3 returns zero.
- R7: A line-start pulse before the sixteenth payload bit drops the partial capture. Byte registers and flags keep their old values, and hunting for the preamble restarts.
- R8: A read strobe at address 1 clears the available flag. If a capture completes in the same cycle, the flag is set.
- R9: Once a line has been captured, further bits are ignored until the next line-start pulse.
- R10: The data bit has no effect in cycles where the bit strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle pulse at the start of a video line |
| bit_valid | input | 1 | Strobe: bit_in carries a sliced bit this cycle |
| bit_in | input | 1 | Sliced serial data bit |
| rd_en | input | 1 | Host read strobe (side effect: clears available at address 1) |
| rd_addr | input | 2 | Host read address |
| rd_data | output | 8 | Read data for rd_addr |

## Verification
The assertions assume that line_start and bit_valid are synchronous single-cycle pulses. They also assume that a read strobe is a single-cycle pulse, so the flag relations can be checked from one cycle to the next. The stimulus drives every input on the falling edge. It never asserts line_start together with a bit strobe, and it leaves at least one idle cycle between bit strobes, with bit_in toggled during that gap. The main sweep runs every possible first-character value through complete lines, paired with an arithmetically derived second character. Extra lines cover a broken run-in, an aborted payload, bits after a capture, and a host read that coincides with a capture.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_DATA = 2'd1,
    ST_DONE = 2'd2
  } ccd_state_e;
endpackage

// File: rtl/ccd_preamble_det.sv
`timescale 1ns/1ps
// Sliding-window matcher for the run-in plus start pattern.
// The window is cleared to zero, so PATTERN must have its top bit set so that a
// partially filled window can never match.
module ccd_preamble_det #(
  parameter int unsigned      LEN     = 10,
  parameter logic [LEN-1:0]   PATTERN = 10'b1010101001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic hit
);
  logic [LEN-1:0] win_q, win_d, win_next;

  assign win_next = {win_q[LEN-2:0], bit_in};
  assign hit      = shift_en && (win_next == PATTERN);

  always_comb begin
    win_d = win_q;
    if (clr)           win_d = '0;
    else if (shift_en) win_d = win_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '0;
    else        win_q <= win_d;
  end
endmodule

// File: rtl/ccd_deser.sv
`timescale 1ns/1ps
// Line state machine and payload deserializer (LSB first).
module ccd_deser
  import ccd_pkg::*;
#(
  parameter int unsigned NBITS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_start,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             hit,
  output logic             hunting,
  output logic             done,
  output logic [NBITS-1:0] word,
  output ccd_state_e       state
);
  localparam int unsigned CNT_W = $clog2(NBITS);

  ccd_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [NBITS-1:0] sh_q;
  logic             sh_en;

  assign state   = state_q;
  assign hunting = (state_q == ST_HUNT) && !line_start;
  assign sh_en   = (state_q == ST_DATA) && !line_start && bit_valid;
  assign word    = {bit_in, sh_q[NBITS-1:1]};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done    = 1'b0;
    if (line_start) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_HUNT: if (hit) begin
          state_d = ST_DATA;
          cnt_d   = '0;
        end
        ST_DATA: if (bit_valid) begin
          if (cnt_q == CNT_W'(NBITS - 1)) begin
            done    = 1'b1;
            state_d = ST_DONE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Payload shifter: data path only, no reset needed.
  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= word;
  end
endmodule

// File: rtl/ccd_regs.sv
`timescale 1ns/1ps
// Readback byte registers, flags and host read mux.
module ccd_regs #(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned NCHAR  = 2,
  parameter int unsigned AW     = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    capture,
  input  logic [NCHAR*CHAR_W-1:0] word,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic [CHAR_W-1:0]       rd_data,
  output logic                    avail,
  output logic [NCHAR-1:0]        perr
);
  logic [CHAR_W-1:0] byte_q [NCHAR];
  logic [NCHAR-1:0]  perr_d;
  logic              avail_d, rd_clr;
  logic [CHAR_W-1:0] stat;

  assign rd_clr = rd_en && (rd_addr == AW'(NCHAR - 1));

  for (genvar i = 0; i < NCHAR; i++) begin : g_char
    logic [CHAR_W-1:0] ch;
    assign ch        = word[i*CHAR_W +: CHAR_W];
    assign perr_d[i] = capture ? ~(^ch) : perr[i];
    always_ff @(posedge clk) begin
      if (capture) byte_q[i] <= ch;
    end
  end

  always_comb begin
    avail_d = avail;
    if (rd_clr)  avail_d = 1'b0;
    if (capture) avail_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail <= 1'b0;
      perr  <= '0;
    end else begin
      avail <= avail_d;
      perr  <= perr_d;
    end
  end

  always_comb begin
    stat            = '0;
    stat[0]         = avail;
    stat[NCHAR:1]   = perr;
    rd_data         = '0;
    for (int i = 0; i < NCHAR; i++) begin
      if (rd_addr == AW'(i)) rd_data = byte_q[i];
    end
    if (rd_addr == AW'(NCHAR)) rd_data = stat;
  end
endmodule

// File: rtl/ccd_line_decoder.sv
`timescale 1ns/1ps
module ccd_line_decoder
  import ccd_pkg::*;
#(
  parameter int unsigned         CHAR_W  = 8,
  parameter int unsigned         NCHAR   = 2,
  parameter int unsigned         PRE_LEN = 10,
  parameter logic [PRE_LEN-1:0]  PRE_PAT = 10'b1010101001,
  localparam int unsigned        AW      = $clog2(NCHAR + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [CHAR_W-1:0] rd_data
);
  localparam int unsigned NBITS = CHAR_W * NCHAR;

  logic             rst_meta, rst_sync_n;
  logic             hit, hunting, done;
  logic [NBITS-1:0] word;
  logic             avail;
  logic [NCHAR-1:0] perr;
  ccd_state_e       state;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ccd_preamble_det #(.LEN(PRE_LEN), .PATTERN(PRE_PAT)) u_det (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (line_start),
    .shift_en (hunting && bit_valid),
    .bit_in   (bit_in),
    .hit      (hit)
  );

  ccd_deser #(.NBITS(NBITS)) u_deser (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .line_start (line_start),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .hit        (hit),
    .hunting    (hunting),
    .done       (done),
    .word       (word),
    .state      (state)
  );

  ccd_regs #(.CHAR_W(CHAR_W), .NCHAR(NCHAR), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .capture (done),
    .word    (word),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .avail   (avail),
    .perr    (perr)
  );
endmodule

// File: rtl/ccd_line_decoder_chk.sv
`timescale 1ns/1ps
module ccd_line_decoder_chk
  import ccd_pkg::*;
#(
  parameter int unsigned CHAR_W = 8,
  parameter int unsigned NCHAR  = 2,
  parameter int unsigned AW     = 2
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    line_start,
  input logic                    rd_en,
  input logic [AW-1:0]           rd_addr,
  input logic                    done,
  input logic [NCHAR*CHAR_W-1:0] word,
  input logic                    avail,
  input logic [NCHAR-1:0]        perr,
  input ccd_state_e              state
);
  // R4: a completed capture raises the available flag on the next cycle
  a_r4_capture_sets_avail: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> avail);

  // R5: odd parity, flag set on even count
  a_r5_parity_char0: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (perr[0] == ~(^$past(word[CHAR_W-1:0]))));

  a_r5_parity_char1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |=> (perr[1] == ~(^$past(word[2*CHAR_W-1:CHAR_W]))));

  // R8: read of the last byte register clears availability unless a capture lands
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && rd_addr == AW'(NCHAR - 1) && !done) |=> !avail);

  // R7: flags only move on a capture
  a_r7_flags_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !done |=> $stable(perr));

  // R7: a line start always returns to preamble hunting
  a_r7_restart_hunt: assert property (@(posedge clk) disable iff (!rst_sync_n)
    line_start |=> (state == ST_HUNT));
endmodule

bind ccd_line_decoder ccd_line_decoder_chk #(.CHAR_W(CHAR_W), .NCHAR(NCHAR), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .line_start (line_start),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .done       (done),
  .word       (word),
  .avail      (avail),
  .perr       (perr),
  .state      (state)
);

// File: tb/ccd_line_decoder_test.sv
`timescale 1ns/1ps
module ccd_line_decoder_test;
  logic       clk = 1'b0;
  logic       rst_n, line_start, bit_valid, bit_in, rd_en;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;
  logic [7:0] last0, last1;

  always #10 clk = ~clk;

  ccd_line_decoder uut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .bit_valid(bit_valid),
    .bit_in(bit_in), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] stat_of(input logic av, input logic [7:0] a, input logic [7:0] b);
    return {5'b0, ~(^b), ~(^a), av};
  endfunction

  // one strobed bit, then an idle cycle with the opposite level on bit_in (R10)
  task automatic send_bit(input logic b);
    @(negedge clk); bit_valid = 1'b1; bit_in = b;
    @(negedge clk); bit_valid = 1'b0; bit_in = ~b;
  endtask

  task automatic pulse_line();
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
  endtask

  task automatic send_preamble(input logic [9:0] p);
    for (int i = 9; i >= 0; i--) send_bit(p[i]);
  endtask

  task automatic send_chars(input logic [7:0] a, input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) send_bit(i < 8 ? a[i] : b[i-8]);
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a; #2; d = rd_data;
  endtask

  task automatic read_clear();
    @(negedge clk); rd_addr = 2'd1; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic check_regs(input string req, input logic av);
    logic [7:0] d;
    peek(2'd0, d); check(req, d, last0);
    peek(2'd1, d); check(req, d, last1);
    peek(2'd2, d); check(req, d, stat_of(av, last0, last1));
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, a, b;
    rst_n = 1'b0; line_start = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    rd_en = 1'b0; rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R6 unused address
    peek(2'd2, d); check("R1 status after reset", d, 8'h00);
    peek(2'd3, d); check("R6 address 3", d, 8'h00);

    // Sweep all first-character values: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < 256; v++) begin
      a = 8'(v);
      b = 8'(v * 37 + 11);
      pulse_line();
      send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);   // junk ahead of run-in (R2)
      send_preamble(10'b1010101001);
      send_chars(a, b, 16);
      last0 = a; last1 = b;
      check_regs("R3 R4 R5 capture", 1'b1);
      read_clear();
      peek(2'd2, d); check("R8 read clears avail", d, stat_of(1'b0, a, b));
    end

    // R2: broken run-in, zero payload, no capture
    pulse_line();
    send_preamble(10'b1010111001);
    send_chars(8'h00, 8'h00, 16);
    check_regs("R2 broken run-in", 1'b0);

    // R7: abort mid-payload, then a fresh line is captured
    pulse_line();
    send_preamble(10'b1010101001);
    send_chars(8'h3C, 8'hC3, 12);
    pulse_line();
    check_regs("R7 abort keeps old", 1'b0);
    send_bit(1'b0);
    send_preamble(10'b1010101001);
    send_chars(8'h81, 8'h7E, 16);
    last0 = 8'h81; last1 = 8'h7E;
    check_regs("R7 restart capture", 1'b1);

    // R9: bits after a capture are ignored
    send_preamble(10'b1010101001);
    send_chars(8'hFF, 8'h00, 16);
    check_regs("R9 ignored after capture", 1'b1);
    read_clear();

    // R8: read at address 1 together with the final payload bit keeps avail set
    pulse_line();
    send_preamble(10'b1010101001);
    send_chars(8'h55, 8'h2A, 15);
    @(negedge clk); bit_valid = 1'b1; bit_in = 1'b0; rd_en = 1'b1; rd_addr = 2'd1;
    @(negedge clk); bit_valid = 1'b0; rd_en = 1'b0;
    last0 = 8'h55; last1 = 8'h2A;
    check_regs("R8 capture wins over clear", 1'b1);
    read_clear();
    peek(2'd2, d); check("R8 cleared after", d, stat_of(1'b0, 8'h55, 8'h2A));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule